// File: doc/BRIEF.md
# Vectored Interrupt Controller with Context Shadow

This block is the interrupt controller for a small 4-bit microcontroller core. It watches eight request sources: two external pins, each with its own selectable edge, four timer underflow pulses, an A-D conversion-done pulse and a serial-transfer-done pulse. Each source latches a request flag that stays set until the request is serviced or software clears it. A per-source enable bit and a master enable decide whether a pending request is taken.

Requests are only considered at instruction boundaries, which the core marks with `instr_done`. When a request is accepted, the block does four things at once:
- it hands the core a vector in page 1 and the return address to push;
- it clears the master enable;
- it clears only the serviced flag;
- it copies the data pointer, carry, skip and the A and B registers into a one-deep shadow.

On the RTI boundary the block raises a restore strobe, which tells the core to pop the return address and to take the context back from the shadow outputs. EI takes effect one instruction late. DI takes effect at once.

Top module: `irq_vector_ctrl`

## Requirements
- R1: `req_flags` bit order is 0 = pin 0, 1 = pin 1, 2..5 = timer 1..4 underflow, 6 = A-D done, 7 = serial done. A source event sets its flag at the next clock edge, so the flag is visible one cycle later.
- R2: Each pin is compared with its value from the previous cycle. When `pin_rise[i]` is 1 a low-to-high change is a request; when it is 0 a high-to-low change is a request. In the first cycle after reset no pin edge is recognised.
- R3: A flag stays set until it is serviced or a 1 is written to its bit of `flag_clr`, whatever its enable bit is. If a new event for a source comes in the same cycle as a clear of its flag, the event wins.
- R4: A request is accepted at a cycle with `instr_done`=1, `ime`=1, `di_cmd`=0 and `rti_cmd`=0, when at least one flag is set together with its `src_en` bit. `irq_take` is high for the one following cycle.
- R5: Among the enabled pending flags, the lowest bit index wins. `vec_addr` is {page 1, line 2×index}, which with the defaults is 128 + 2×index. Only the winning flag is cleared; all other flags keep their state.
- R6: On acceptance, `ret_addr` takes the value of `next_pc`, `ime` goes to 0, and any EI still waiting to take effect is cancelled.
- R7: On acceptance, the shadow captures `cur_dp`, `cur_cy`, `cur_sk`, `cur_a` and `cur_b`. The shadow keeps these values until the next acceptance. An RTI boundary makes `ctx_restore` high for the following cycle, and that strobe never coincides with `irq_take`.
- R8: After a boundary that carries `ei_cmd`, `ime` becomes 1 at the next boundary. So EI placed just before RTI sets `ime` on the RTI boundary, and the first acceptance after it can only happen at a later boundary.
- R9: A boundary with `di_cmd` clears `ime` at that boundary, blocks acceptance at that boundary, and cancels any waiting EI.
- R10: `ei_cmd`, `di_cmd` and `rti_cmd` have no effect in cycles where `instr_done` is 0.
- R11: After reset, the flags, `ime`, `irq_take`, `ctx_restore`, `vec_addr`, `ret_addr` and the shadow are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | 2 | External request pin levels |
| pin_rise | input | 2 | Edge select per pin: 1 = rising, 0 = falling |
| tmr_uf | input | 4 | Timer 1..4 underflow pulses |
| adc_done | input | 1 | A-D conversion complete pulse |
| sio_done | input | 1 | Serial transfer complete pulse |
| src_en | input | 8 | Per-source enable bits |
| flag_clr | input | 8 | Software clear mask for the flags |
| instr_done | input | 1 | Instruction boundary strobe |
| ei_cmd | input | 1 | The finishing instruction is EI |
| di_cmd | input | 1 | The finishing instruction is DI |
| rti_cmd | input | 1 | The finishing instruction is RTI |
| next_pc | input | PAGE_BITS+LINE_BITS | Address to resume at after an interrupt |
| cur_dp | input | DP_BITS | Current data pointer |
| cur_cy | input | 1 | Current carry flag |
| cur_sk | input | 1 | Current skip flag |
| cur_a | input | NIB | Current register A |
| cur_b | input | NIB | Current register B |
| req_flags | output | 8 | Latched request flags |
| ime | output | 1 | Master interrupt enable |
| irq_take | output | 1 | Acceptance strobe: jump to vector and push return |
| vec_addr | output | PAGE_BITS+LINE_BITS | Vector of the accepted source |
| ret_addr | output | PAGE_BITS+LINE_BITS | Return address to push |
| ctx_restore | output | 1 | RTI strobe: pop return and reload context |
| sav_dp | output | DP_BITS | Shadowed data pointer |
| sav_cy | output | 1 | Shadowed carry |
| sav_sk | output | 1 | Shadowed skip flag |
| sav_a | output | NIB | Shadowed register A |
| sav_b | output | NIB | Shadowed register B |

## Verification
The hardest case to reach is the one where three things meet on consecutive boundaries. An interrupt service routine runs EI and then RTI, and a further request has been latched inside that routine. The master enable must come up exactly at the RTI boundary, the restore must happen, and the new request must only be taken one boundary later. A directed sequence builds this case step by step: a timer pulse while interrupts are disabled, a delayed EI, an acceptance, an A-D pulse inside the routine, then EI followed by RTI. Long stretches of mixed stimulus follow, in which the command strobes also arrive off-boundary and clears collide with new events. These runs cover priority, DI cancelling a waiting EI, and command strobes that must be ignored.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int PAGE_BITS = 6,
  parameter int LINE_BITS = 7,
  parameter int DP_BITS   = 6,
  parameter int NIB       = 4,
  parameter int VEC_PAGE  = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     pin_lvl,
  input  logic [1:0]                     pin_rise,
  input  logic [3:0]                     tmr_uf,
  input  logic                           adc_done,
  input  logic                           sio_done,
  input  logic [7:0]                     src_en,
  input  logic [7:0]                     flag_clr,
  input  logic                           instr_done,
  input  logic                           ei_cmd,
  input  logic                           di_cmd,
  input  logic                           rti_cmd,
  input  logic [PAGE_BITS+LINE_BITS-1:0] next_pc,
  input  logic [DP_BITS-1:0]             cur_dp,
  input  logic                           cur_cy,
  input  logic                           cur_sk,
  input  logic [NIB-1:0]                 cur_a,
  input  logic [NIB-1:0]                 cur_b,
  output logic [7:0]                     req_flags,
  output logic                           ime,
  output logic                           irq_take,
  output logic [PAGE_BITS+LINE_BITS-1:0] vec_addr,
  output logic [PAGE_BITS+LINE_BITS-1:0] ret_addr,
  output logic                           ctx_restore,
  output logic [DP_BITS-1:0]             sav_dp,
  output logic                           sav_cy,
  output logic                           sav_sk,
  output logic [NIB-1:0]                 sav_a,
  output logic [NIB-1:0]                 sav_b
);
  localparam int NSRC = 8;
  localparam int IW   = $clog2(NSRC);

  logic [1:0]      pin_q;
  logic            pin_armed;
  logic [1:0]      pin_edge;
  logic [NSRC-1:0] raise, pend, grant;
  logic [IW-1:0]   win;
  logic            accept, ei_wait;

  for (genvar i = 0; i < 2; i++) begin : g_pin
    assign pin_edge[i] = pin_armed &
      (pin_rise[i] ? (pin_lvl[i] & ~pin_q[i]) : (~pin_lvl[i] & pin_q[i]));
  end

  assign raise  = {sio_done, adc_done, tmr_uf, pin_edge};
  assign pend   = req_flags & src_en;
  assign accept = instr_done & ime & ~di_cmd & ~rti_cmd & (|pend);

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) win = IW'(i);
  end

  assign grant = accept ? (NSRC'(1) << win) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q     <= '0;
      pin_armed <= 1'b0;
      req_flags <= '0;
    end else begin
      pin_q     <= pin_lvl;
      pin_armed <= 1'b1;
      req_flags <= (req_flags & ~flag_clr & ~grant) | raise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ime     <= 1'b0;
      ei_wait <= 1'b0;
    end else if (accept || (instr_done && di_cmd)) begin
      ime     <= 1'b0;
      ei_wait <= 1'b0;
    end else if (instr_done) begin
      if (ei_wait) ime <= 1'b1;
      ei_wait <= ei_cmd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_take    <= 1'b0;
      ctx_restore <= 1'b0;
      vec_addr    <= '0;
      ret_addr    <= '0;
      sav_dp      <= '0;
      sav_cy      <= 1'b0;
      sav_sk      <= 1'b0;
      sav_a       <= '0;
      sav_b       <= '0;
    end else begin
      irq_take    <= accept;
      ctx_restore <= instr_done & rti_cmd;
      if (accept) begin
        vec_addr <= {PAGE_BITS'(VEC_PAGE), LINE_BITS'({win, 1'b0})};
        ret_addr <= next_pc;
        sav_dp   <= cur_dp;
        sav_cy   <= cur_cy;
        sav_sk   <= cur_sk;
        sav_a    <= cur_a;
        sav_b    <= cur_b;
      end
    end
  end

  assert_take_needs_ime_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(ime));
  assert_take_closes_ime_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> !ime);
  assert_no_take_and_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_take && ctx_restore));
  assert_ime_rises_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ime) |-> $past(instr_done));
  assert_di_closes_ime_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && di_cmd) |=> !ime);
  assert_ime_quiet_off_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> $stable(ime));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] pin_lvl = 0, pin_rise = 0;
  logic [3:0] tmr_uf = 0;
  logic adc_done = 0, sio_done = 0;
  logic [7:0] src_en = 0, flag_clr = 0;
  logic instr_done = 0, ei_cmd = 0, di_cmd = 0, rti_cmd = 0;
  logic [12:0] next_pc = 0;
  logic [5:0] cur_dp = 0;
  logic cur_cy = 0, cur_sk = 0;
  logic [3:0] cur_a = 0, cur_b = 0;
  logic [7:0] req_flags;
  logic ime, irq_take, ctx_restore, sav_cy, sav_sk;
  logic [12:0] vec_addr, ret_addr;
  logic [5:0] sav_dp;
  logic [3:0] sav_a, sav_b;

  irq_vector_ctrl u_irq_vector_ctrl (.*);

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // reference model
  bit m_flag[8];
  bit m_ime, m_eiw, m_armed, m_take, m_rest;
  bit m_prev[2];
  int m_vec, m_ret, m_sav;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_flag[i]) m_flag[i] = 0;
      m_ime = 0; m_eiw = 0; m_armed = 0; m_take = 0; m_rest = 0;
      m_prev[0] = 0; m_prev[1] = 0;
      m_vec = 0; m_ret = 0; m_sav = 0;
    end else begin
      bit ev[8];
      int w;
      bit acc;
      for (int i = 0; i < 2; i++) begin
        if (pin_rise[i]) ev[i] = m_armed && pin_lvl[i] && !m_prev[i];
        else             ev[i] = m_armed && !pin_lvl[i] && m_prev[i];
      end
      for (int i = 0; i < 4; i++) ev[2+i] = tmr_uf[i];
      ev[6] = adc_done; ev[7] = sio_done;
      w = -1;
      for (int i = 7; i >= 0; i--) if (m_flag[i] && src_en[i]) w = i;
      acc = instr_done && m_ime && !di_cmd && !rti_cmd && (w >= 0);
      for (int i = 0; i < 8; i++)
        m_flag[i] = (m_flag[i] && !flag_clr[i] && !(acc && i == w)) || ev[i];
      if (acc || (instr_done && di_cmd)) begin
        m_ime = 0; m_eiw = 0;
      end else if (instr_done) begin
        if (m_eiw) m_ime = 1;
        m_eiw = ei_cmd;
      end
      m_take = acc;
      m_rest = instr_done && rti_cmd;
      if (acc) begin
        m_vec = 128 + 2 * w;
        m_ret = next_pc;
        m_sav = {cur_dp, cur_cy, cur_sk, cur_a, cur_b};
      end
      m_prev[0] = pin_lvl[0]; m_prev[1] = pin_lvl[1];
      m_armed = 1;
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int fl;
      fl = 0;
      for (int i = 0; i < 8; i++) fl |= int'(m_flag[i]) << i;
      chk(req_flags == fl[7:0], "R1 R2 R3 R5 flags", req_flags, fl);
      chk(ime == m_ime, "R6 R8 R9 R10 ime", ime, m_ime);
      chk(irq_take == m_take, "R4 take", irq_take, m_take);
      chk(vec_addr == m_vec[12:0], "R5 vector", vec_addr, m_vec);
      chk(ret_addr == m_ret[12:0], "R6 return", ret_addr, m_ret);
      chk(ctx_restore == m_rest, "R7 restore", ctx_restore, m_rest);
      chk({sav_dp, sav_cy, sav_sk, sav_a, sav_b} == m_sav[15:0], "R7 shadow",
          {sav_dp, sav_cy, sav_sk, sav_a, sav_b}, m_sav);
    end
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bound(input bit ei, input bit di, input bit rti);
    instr_done = 1; ei_cmd = ei; di_cmd = di; rti_cmd = rti;
    cyc();
    instr_done = 0; ei_cmd = 0; di_cmd = 0; rti_cmd = 0;
  endtask

  initial begin
    #150000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_flags == 0 && ime == 0 && irq_take == 0 && ctx_restore == 0, "R11 reset outputs",
        {req_flags, ime, irq_take, ctx_restore}, 0);
    chk(vec_addr == 0 && ret_addr == 0 && sav_a == 0, "R11 reset addresses", vec_addr, 0);
    rst_n = 1;
    cmp_on = 1;
    src_en = 8'hFF;
    cyc();
    // directed: latch while disabled, delayed EI, accept, EI before RTI
    tmr_uf[1] = 1; cyc(); tmr_uf[1] = 0;
    chk(req_flags == 8'h08, "R1 R3 timer2 flag kept", req_flags, 8'h08);
    bound(1, 0, 0);
    chk(ime == 0, "R8 ime not yet on", ime, 0);
    bound(0, 0, 0);
    chk(ime == 1, "R8 ime on after next boundary", ime, 1);
    next_pc = 13'h0A5; cur_dp = 6'h2B; cur_cy = 1; cur_sk = 0; cur_a = 4'h9; cur_b = 4'h6;
    bound(0, 0, 0);
    chk(irq_take == 1 && vec_addr == 13'd134, "R4 R5 timer2 vector", vec_addr, 134);
    chk(ret_addr == 13'h0A5, "R6 return address", ret_addr, 13'h0A5);
    chk(ime == 0 && req_flags == 0, "R5 R6 flag and ime cleared", {ime, req_flags}, 0);
    cur_dp = 0; cur_cy = 0; cur_a = 0; cur_b = 0;
    adc_done = 1; cyc(); adc_done = 0;
    bound(1, 0, 0);
    bound(0, 0, 1);
    chk(ctx_restore == 1 && irq_take == 0, "R7 restore strobe", ctx_restore, 1);
    chk({sav_dp, sav_cy, sav_sk, sav_a, sav_b} == {6'h2B, 1'b1, 1'b0, 4'h9, 4'h6}, "R7 shadow content",
        {sav_dp, sav_cy, sav_sk, sav_a, sav_b}, {6'h2B, 1'b1, 1'b0, 4'h9, 4'h6});
    chk(ime == 1, "R8 ime on at RTI boundary", ime, 1);
    bound(0, 0, 0);
    chk(irq_take == 1 && vec_addr == 13'd140, "R4 R5 adc vector", vec_addr, 140);
    // off-boundary commands ignored, DI cancels waiting EI
    ei_cmd = 1; cyc(); ei_cmd = 0; bound(0, 0, 0);
    chk(ime == 0, "R10 EI without boundary ignored", ime, 0);
    bound(1, 0, 0); bound(0, 1, 0); bound(0, 0, 0);
    chk(ime == 0, "R9 DI cancels waiting EI", ime, 0);
    // pin edges and clear/event collision
    pin_rise = 2'b01; pin_lvl = 2'b11; cyc();
    chk(req_flags[0] == 1 && req_flags[1] == 0, "R2 rising pin0 only", req_flags[1:0], 2'b01);
    pin_lvl = 2'b00; cyc();
    chk(req_flags[1] == 1, "R2 falling pin1", req_flags[1], 1);
    flag_clr = 8'h03; tmr_uf = 4'h1; cyc(); flag_clr = 0; tmr_uf = 0;
    chk(req_flags == 8'h04, "R3 clear and event collision", req_flags, 8'h04);
    // mixed stimulus
    for (int k = 0; k < 6000; k++) begin
      instr_done = ($urandom % 2) == 0;
      ei_cmd  = ($urandom % 6) == 0;
      di_cmd  = ($urandom % 14) == 0;
      rti_cmd = ($urandom % 9) == 0;
      tmr_uf  = 4'($urandom) & 4'($urandom) & 4'($urandom);
      adc_done = ($urandom % 8) == 0;
      sio_done = ($urandom % 8) == 0;
      flag_clr = ($urandom % 10) == 0 ? 8'($urandom) : 8'h00;
      if (($urandom % 16) == 0) src_en = 8'($urandom);
      if (($urandom % 4) == 0) pin_lvl = 2'($urandom);
      if (($urandom % 300) == 0) pin_rise = 2'($urandom);
      next_pc = 13'($urandom);
      {cur_dp, cur_cy, cur_sk, cur_a, cur_b} = 16'($urandom);
      cyc();
    end
    finish_up();
  end
endmodule